// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block supervises software progress. A down-counter, reloaded to all ones, decrements once per prescaler output tick. The prescaler divides the CPU clock-enable ticks by one of three ratios. When the CPU runs from the slow secondary clock, the ratio is fixed. When it runs from any of the fast sources, a select bit picks between two ratios. Software must write the kick strobe before the counter runs out.

If the counter runs out, the block raises either a one-cycle interrupt request or a one-cycle reset request. The choice comes from a sticky mode bit. Software can set this bit but cannot clear it. A freeze input stands for the stop, wait and hold states. While it is high, all counting halts and the state is kept.

After a system reset the block is idle: nothing counts until the first kick. Time is measured in cycles of `cpu_tick`, the CPU clock enable.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` is low and right after it is released, `count_o` is all ones (2^CNT_W-1), and both `irq_o` and `rst_req_o` are low.
- R2: With `sub_clk`=0 and `div_hi`=0, the prescaler ratio is DIV_MAIN_LO. An underflow in interrupt mode (mode bit 0) gives a one-cycle `irq_o` pulse and reloads the counter. Successive pulses are therefore DIV_MAIN_LO × 2^CNT_W ticks apart.
- R3: With `sub_clk`=0 and `div_hi`=1, the ratio is DIV_MAIN_HI. Interrupts are then DIV_MAIN_HI × 2^CNT_W ticks apart.
- R4: With `sub_clk`=1, the ratio is DIV_SUB whatever `div_hi` holds. Interrupts are then DIV_SUB × 2^CNT_W ticks apart.
- R5: A cycle with `mode_wr`=1 and `mode_wdata`=1 sets the mode bit to 1. A write with `mode_wdata`=0 is ignored, so later underflows still give reset requests.
- R6: With the mode bit at 1, an underflow gives a one-cycle `rst_req_o` pulse and no `irq_o`. The two outputs are never high together.
- R7: A `kick` reloads the counter to all ones in the next cycle. The prescaler is not touched. Its counter runs modulo the largest ratio and emits a tick each time its low log2(ratio) bits are all ones. Therefore the first decrement after a kick follows the running prescaler phase.
- R8: After reset, the counter and prescaler stay stopped until the first `kick`, and no request is raised.
- R9: While `freeze`=1, neither the counter nor the prescaler advances. Counting resumes from the held values once `freeze` falls. `cpu_tick`=0 likewise stops both for that cycle.
- R10: A `kick` in the cycle an underflow would occur wins. The counter reloads and neither request is raised.
- R11: After a reset request, the block is in its post-reset state: idle, prescaler cleared, mode bit 0. A later kick restarts it in interrupt mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| cpu_tick | input | 1 | Clock enable; one count opportunity per high cycle |
| sub_clk | input | 1 | 1 when the CPU runs from the slow secondary clock |
| div_hi | input | 1 | Fast-clock ratio select: 0 low ratio, 1 high ratio |
| kick | input | 1 | Service strobe; reloads the counter and starts the timer |
| mode_wr | input | 1 | Mode-bit write strobe |
| mode_wdata | input | 1 | Mode value written; only 1 has an effect |
| freeze | input | 1 | Stop/wait/hold indication; halts all counting |
| irq_o | output | 1 | One-cycle interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |
| count_o | output | CNT_W | Current counter value |

## Verification
The bench builds the block with CNT_W=5 and ratios 4, 8 and 2. A full period then spans 64 to 256 cycles instead of millions. This makes it possible to measure many whole periods, switch between all three ratios, and cycle through both modes and the reset-request return to idle. The short period also puts a kick exactly on an underflow cycle and a kick at a chosen prescaler phase within a few hundred cycles. A behavioural model is compared with the outputs on every clock, including a stretch with an irregular clock-enable pattern.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_IRQ  = 2'd1,
    EV_RST  = 2'd2
  } wdt_event_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
// Free-running divider; ratios must be powers of two no larger than the
// biggest one. Cleared only by reset or a reset-request event.
module wdt_prescaler #(
  parameter int DIV_LO  = 16,
  parameter int DIV_HI  = 128,
  parameter int DIV_SUB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic clr_i,
  input  logic sub_sel_i,
  input  logic hi_sel_i,
  output logic tick_o
);
  localparam int DIV_MAX = wdt_pkg::max3(DIV_LO, DIV_HI, DIV_SUB);
  localparam int PRE_W   = $clog2(DIV_MAX);
  localparam logic [PRE_W-1:0] MASK_LO  = PRE_W'(DIV_LO - 1);
  localparam logic [PRE_W-1:0] MASK_HI  = PRE_W'(DIV_HI - 1);
  localparam logic [PRE_W-1:0] MASK_SUB = PRE_W'(DIV_SUB - 1);

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    if (sub_sel_i)     mask = MASK_SUB;
    else if (hi_sel_i) mask = MASK_HI;
    else               mask = MASK_LO;
  end

  always_comb begin
    pre_d = pre_q;
    if (clr_i)      pre_d = '0;
    else if (adv_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = adv_i && ((pre_q & mask) == mask);

endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (reload_i)   cnt_d = '1;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);

endmodule

// File: rtl/wdt_mode_ctl.sv
// Sticky outcome select: 0 interrupt, 1 reset. Set-only by software.
module wdt_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic clr_i,
  output logic mode_o
);
  logic mode_q, mode_d;

  always_comb begin
    mode_d = mode_q | (wr_i & wdata_i);
    if (clr_i) mode_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W       = 15,
  parameter int DIV_MAIN_LO = 16,
  parameter int DIV_MAIN_HI = 128,
  parameter int DIV_SUB     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_tick,
  input  logic             sub_clk,
  input  logic             div_hi,
  input  logic             kick,
  input  logic             mode_wr,
  input  logic             mode_wdata,
  input  logic             freeze,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic [CNT_W-1:0] count_o
);
  import wdt_pkg::*;

  logic       run_q, run_d;
  logic       irq_q, rst_q;
  logic       adv, tick, zero, uf, reload, rst_ev;
  logic       mode_q;
  wdt_event_e ev;

  assign adv = run_q & cpu_tick & ~freeze;

  wdt_prescaler #(
    .DIV_LO (DIV_MAIN_LO),
    .DIV_HI (DIV_MAIN_HI),
    .DIV_SUB(DIV_SUB)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv),
    .clr_i    (rst_ev),
    .sub_sel_i(sub_clk),
    .hi_sel_i (div_hi),
    .tick_o   (tick)
  );

  // Underflow: a tick while at zero, unless a kick lands in the same cycle.
  assign uf = tick & zero & ~kick;

  always_comb begin
    ev = EV_NONE;
    if (uf) ev = mode_q ? EV_RST : EV_IRQ;
  end

  assign rst_ev = (ev == EV_RST);
  assign reload = kick | uf;

  wdt_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload_i(reload),
    .dec_i   (tick),
    .count_o (count_o),
    .zero_o  (zero)
  );

  wdt_mode_ctl u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (mode_wr),
    .wdata_i(mode_wdata),
    .clr_i  (rst_ev),
    .mode_o (mode_q)
  );

  always_comb begin
    run_d = run_q;
    if (rst_ev)    run_d = 1'b0;
    else if (kick) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      run_q <= run_d;
      irq_q <= (ev == EV_IRQ);
      rst_q <= rst_ev;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kick,
  input logic             freeze,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] count_o,
  input logic             mode_q,
  input logic             run_q
);
  assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_req_o));

  assert_irq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_kick_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count_o == {CNT_W{1'b1}}) && !irq_o && !rst_req_o);

  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !kick) |=> $stable(count_o));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !kick) |=> $stable(count_o) && !irq_o && !rst_req_o);

  assert_mode_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q) |-> rst_req_o);

  assert_rst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (count_o == {CNT_W{1'b1}}) && !run_q && !mode_q);

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_wdog_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .kick     (kick),
  .freeze   (freeze),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o),
  .count_o  (count_o),
  .mode_q   (mode_q),
  .run_q    (run_q)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int CW = 5;
  localparam int DL = 4;
  localparam int DH = 8;
  localparam int DS = 2;
  localparam int PMOD = 8;
  localparam int RLD = 31;

  logic clk;
  logic rst_n, cpu_tick, sub_clk, div_hi, kick, mode_wr, mode_wdata, freeze;
  logic irq_o, rst_req_o;
  logic [CW-1:0] count_o;

  int compared, mismatched, cyc;
  bit done;

  // behavioural reference state
  int m_cnt, m_pre;
  bit m_run, m_mode, m_irq, m_rst;

  wdog_timer #(.CNT_W(CW), .DIV_MAIN_LO(DL), .DIV_MAIN_HI(DH), .DIV_SUB(DS)) i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .sub_clk(sub_clk), .div_hi(div_hi),
    .kick(kick), .mode_wr(mode_wr), .mode_wdata(mode_wdata), .freeze(freeze),
    .irq_o(irq_o), .rst_req_o(rst_req_o), .count_o(count_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ratio();
    if (sub_clk) return DS;
    return div_hi ? DH : DL;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = RLD; m_pre = 0; m_run = 0; m_mode = 0; m_irq = 0; m_rst = 0;
    end else begin
      bit adv, tk, nmode;
      int d;
      d = ratio();
      adv = m_run && cpu_tick && !freeze;
      tk = adv && ((m_pre % d) == d - 1);
      if (adv) m_pre = (m_pre + 1) % PMOD;
      nmode = m_mode || (mode_wr && mode_wdata);
      m_irq = 0; m_rst = 0;
      if (kick) begin
        m_cnt = RLD; m_run = 1;
      end else if (tk) begin
        if (m_cnt == 0) begin
          m_cnt = RLD;
          if (m_mode) begin
            m_rst = 1; m_run = 0; m_pre = 0; nmode = 0;
          end else m_irq = 1;
        end else m_cnt = m_cnt - 1;
      end
      m_mode = nmode;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model (R1..R11 as covered by stimulus)
  always @(negedge clk) if (!done) begin
    chk("R2 model count", int'(count_o), m_cnt);
    chk("R6 model irq", int'(irq_o), int'(m_irq));
    chk("R6 model rst_req", int'(rst_req_o), int'(m_rst));
  end

  task automatic wait_event(input bit want_rst, output int at);
    at = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (want_rst ? rst_req_o : irq_o) begin at = cyc; break; end
    end
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1; @(negedge clk); kick = 0;
  endtask

  initial begin
    int t0, t1;
    bit ok;
    compared = 0; mismatched = 0; cyc = 0; done = 0;
    rst_n = 0; cpu_tick = 1; sub_clk = 0; div_hi = 0; kick = 0;
    mode_wr = 0; mode_wdata = 0; freeze = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(count_o), RLD);
    chk("R1 reset irq", int'(irq_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", int'(count_o), RLD);

    // R8: idle without a kick
    ok = 1;
    repeat (60) begin @(negedge clk); if (count_o != RLD || irq_o || rst_req_o) ok = 0; end
    chk("R8 idle until kick", int'(ok), 1);

    // R2: low ratio period
    pulse_kick();
    wait_event(0, t0); wait_event(0, t1);
    chk("R2 interval low ratio", t1 - t0, DL * (RLD + 1));

    // R3: high ratio
    div_hi = 1;
    wait_event(0, t0); wait_event(0, t0); wait_event(0, t1);
    chk("R3 interval high ratio", t1 - t0, DH * (RLD + 1));

    // R4: sub clock ignores div_hi
    sub_clk = 1;
    wait_event(0, t0); wait_event(0, t0); wait_event(0, t1);
    chk("R4 interval sub ratio", t1 - t0, DS * (RLD + 1));
    div_hi = 0; sub_clk = 0;

    // R10: kick on the underflow cycle
    div_hi = 1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (m_cnt == 0 && (m_pre % DH) == DH - 1) break;
    end
    kick = 1;
    @(negedge clk); kick = 0;
    chk("R10 no irq on kicked underflow", int'(irq_o), 0);
    chk("R10 reload on kicked underflow", int'(count_o), RLD);

    // R7: kick keeps prescaler phase (kick edge sees phase 5 of 8)
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (m_pre == 5) break;
    end
    kick = 1;
    @(negedge clk); kick = 0;
    @(negedge clk);
    chk("R7 no decrement yet", int'(count_o), RLD);
    @(negedge clk);
    chk("R7 decrement at phase wrap", int'(count_o), RLD - 1);

    // R9: freeze holds, then resumes
    repeat (20) @(negedge clk);
    freeze = 1;
    @(negedge clk);
    t0 = int'(count_o);
    ok = 1;
    repeat (50) begin @(negedge clk); if (int'(count_o) != t0 || irq_o) ok = 0; end
    chk("R9 frozen count held", int'(ok), 1);
    freeze = 0;

    // R9: irregular clock enable, checked by the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); cpu_tick = (i % 3) != 1;
    end
    cpu_tick = 1;

    // R5: writing 0 leaves interrupt mode, then set to 1 and try to clear
    @(negedge clk); mode_wr = 1; mode_wdata = 0;
    @(negedge clk); mode_wr = 0;
    wait_event(0, t0);
    chk("R5 zero write keeps irq mode", int'(irq_o), 1);
    @(negedge clk); mode_wr = 1; mode_wdata = 1;
    @(negedge clk); mode_wdata = 0;
    @(negedge clk); mode_wr = 0;

    // R6: reset request, no interrupt
    ok = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq_o) ok = 0;
      if (rst_req_o) break;
    end
    chk("R6 reset request raised", int'(rst_req_o), 1);
    chk("R6 no irq in reset mode", int'(ok), 1);

    // R11: idle afterwards, mode back to interrupt
    ok = 1;
    repeat (300) begin @(negedge clk); if (count_o != RLD || irq_o || rst_req_o) ok = 0; end
    chk("R11 idle after reset request", int'(ok), 1);
    pulse_kick();
    wait_event(0, t0);
    chk("R11 interrupt mode after restart", int'(irq_o), 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule